// File: doc/BRIEF.md
# False-Hazard History Table

This block sits beside the operand-matching logic of a small in-order pipeline. That logic matches operands speculatively. It compares several candidate register fields against in-flight destinations, so it sometimes raises a stall that is not needed. When later logic finds that a stall was unnecessary, it sends the address of the offending instruction to this table as an insert request. The next time the same instruction is looked up, the table can cancel the stall.

The store is fully associative with four entries. Each entry covers an aligned block of 32 half-word instructions and holds a tag, a valid flag and a 32-bit pattern with one bit per instruction. A bit is set only for an instruction that produced a false hazard. A clear bit means one of two things: there is no history, or the earlier prediction was right. Entries are replaced in least-recently-used order. The lookup is combinational from the stored state. The final stall output is the incoming speculative hazard, masked by a hit whose bit is set.

Top module: `fh_history_table`

## Requirements
- R1: The 17-bit address is split as follows. Bits [16:6] form the tag and bits [5:1] select one of 32 pattern bits. Bit 0 has no effect on lookup or insert.
- R2: After an insert for an address, a lookup of that address in a later cycle returns `lk_hit`=1 and `lk_bit`=1.
- R3: A lookup whose tag matches a valid entry, but whose addressed bit is clear, returns `lk_hit`=1 and `lk_bit`=0.
- R4: `stall_out` equals `spec_hazard` unless the lookup hits with the addressed bit set. In that case `stall_out` is 0.
- R5: An insert with `ins_branch`=1 changes nothing. A later lookup of that address sees the table as it was before.
- R6: A newly allocated entry holds only the inserted bit. All other 31 bits of its pattern read as 0.
- R7: After reset no entry is valid, so every lookup misses.
- R8: An insert that misses fills an invalid entry, if one exists, before it evicts any valid entry.
- R9: When all entries are valid, an insert miss evicts the least recently used entry. A lookup hit makes its entry most recently used, and so does an insert. After reset the order is entry 0 least recent, then entries 1, 2 and 3.
- R10: A lookup and an insert in the same cycle are ordered. The lookup result reflects the state before the insert. Its recency update comes first, then the insert's update.
- R11: With `lk_valid`=0, `lk_hit` and `lk_bit` are 0 and `stall_out` follows `spec_hazard`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 17 | Lookup instruction address |
| spec_hazard | input | 1 | Speculative hazard from operand matching |
| lk_hit | output | 1 | Lookup tag matched a valid entry |
| lk_bit | output | 1 | Addressed pattern bit on a hit |
| stall_out | output | 1 | Final stall after suppression |
| ins_valid | input | 1 | Insert request: false hazard found |
| ins_pc | input | 17 | Address of the instruction with the false hazard |
| ins_branch | input | 1 | The dependence involved a branch in execute; do not record |

## Verification
A lookup and an insert can land in the same cycle. The two interact in two ways: through the pattern bit being written, and through the recency order that both of them update. The bench drives long streams in which both ports are active at once on a small pool of tags. Some of these cases insert the very address being looked up. Others hit one entry while the insert evicts another. Each lookup is judged against a reference model that applies the lookup's recency update before the insert's. The model expects the old contents in the cycle of the insert and the new contents from the next cycle on.

// File: rtl/fht_pkg.sv
package fht_pkg;
  typedef enum logic [1:0] {
    WR_IDLE  = 2'd0,
    WR_SET   = 2'd1,
    WR_ALLOC = 2'd2
  } wr_act_e;
endpackage

// File: rtl/fht_entry.sv
module fht_entry
  import fht_pkg::*;
#(
  parameter int TAG_W = 11,
  parameter int PAT_W = 32,
  localparam int POS_W = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_act_e          wr_act,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [POS_W-1:0] wr_pos,
  output logic             ent_valid,
  output logic [TAG_W-1:0] ent_tag,
  output logic [PAT_W-1:0] ent_pat
);
  logic             valid_q, valid_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic [PAT_W-1:0] pat_q, pat_d;
  logic             en;
  logic [PAT_W-1:0] pos_mask;

  always_comb begin
    pos_mask = '0;
    pos_mask[wr_pos] = 1'b1;
  end

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    pat_d   = pat_q;
    en      = 1'b0;
    unique case (wr_act)
      WR_SET: begin
        en    = 1'b1;
        pat_d = pat_q | pos_mask;
      end
      WR_ALLOC: begin
        en      = 1'b1;
        valid_d = 1'b1;
        tag_d   = wr_tag;
        pat_d   = pos_mask;
      end
      default: en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      pat_q   <= '0;
    end else if (en) begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
      pat_q   <= pat_d;
    end
  end

  assign ent_valid = valid_q;
  assign ent_tag   = tag_q;
  assign ent_pat   = pat_q;

  AST_ALLOC_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act == WR_ALLOC) |=> (valid_q && $countones(pat_q) == 1)); // R6
endmodule

// File: rtl/fht_lru.sv
module fht_lru #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  valid_vec,
  input  logic          a_touch,
  input  logic [IW-1:0] a_idx,
  input  logic          b_touch,
  input  logic [IW-1:0] b_idx,
  output logic [IW-1:0] victim
);
  typedef logic [N-1:0][IW-1:0] rank_t;

  rank_t rank_q, rank_mid, rank_d;
  logic  en;

  function automatic rank_t touch(rank_t r, logic [IW-1:0] e);
    rank_t o;
    o = r;
    for (int k = 0; k < N; k++) begin
      if (r[k] > r[e]) o[k] = r[k] - 1'b1;
    end
    o[e] = IW'(N - 1);
    return o;
  endfunction

  always_comb begin
    rank_mid = a_touch ? touch(rank_q, a_idx) : rank_q;
  end

  always_comb begin
    logic found;
    victim = '0;
    found  = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!found && !valid_vec[k]) begin
        victim = IW'(k);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int k = 0; k < N; k++) begin
        if (rank_mid[k] == '0) victim = IW'(k);
      end
    end
  end

  always_comb begin
    rank_d = b_touch ? touch(rank_mid, b_idx) : rank_mid;
    en     = a_touch | b_touch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) rank_q[k] <= IW'(k);
    end else if (en) begin
      rank_q <= rank_d;
    end
  end

  for (genvar v = 0; v < N; v++) begin : g_perm
    logic [N-1:0] holds_v;
    always_comb begin
      for (int k = 0; k < N; k++) holds_v[k] = (rank_q[k] == IW'(v));
    end
    AST_RANK_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(holds_v)); // R9
  end
endmodule

// File: rtl/fh_history_table.sv
module fh_history_table
  import fht_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int PC_W    = 17,
  parameter int PAT_W   = 32,
  localparam int POS_W  = $clog2(PAT_W),
  localparam int TAG_W  = PC_W - 1 - POS_W,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            spec_hazard,
  output logic            lk_hit,
  output logic            lk_bit,
  output logic            stall_out,
  input  logic            ins_valid,
  input  logic [PC_W-1:0] ins_pc,
  input  logic            ins_branch
);
  logic [TAG_W-1:0] lk_tag, ins_tag;
  logic [POS_W-1:0] lk_pos, ins_pos;

  assign lk_tag  = lk_pc[PC_W-1 -: TAG_W];
  assign lk_pos  = lk_pc[POS_W:1];
  assign ins_tag = ins_pc[PC_W-1 -: TAG_W];
  assign ins_pos = ins_pc[POS_W:1];

  logic [ENTRIES-1:0] ent_valid;
  logic [TAG_W-1:0]   ent_tag [ENTRIES];
  logic [PAT_W-1:0]   ent_pat [ENTRIES];
  logic [ENTRIES*PAT_W-1:0] pat_flat;
  wr_act_e            ent_act [ENTRIES];
  logic [ENTRIES-1:0] lk_match, ins_match;
  logic [IW-1:0]      victim;
  logic [IW-1:0]      lk_idx, ins_idx, b_idx;
  logic [PAT_W-1:0]   lk_sel_pat;
  logic               ins_go, ins_hit;

  assign ins_go  = ins_valid & ~ins_branch;
  assign ins_hit = |ins_match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    fht_entry #(
      .TAG_W (TAG_W),
      .PAT_W (PAT_W)
    ) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_act    (ent_act[i]),
      .wr_tag    (ins_tag),
      .wr_pos    (ins_pos),
      .ent_valid (ent_valid[i]),
      .ent_tag   (ent_tag[i]),
      .ent_pat   (ent_pat[i])
    );

    assign lk_match[i]  = ent_valid[i] && (ent_tag[i] == lk_tag);
    assign ins_match[i] = ent_valid[i] && (ent_tag[i] == ins_tag);
    assign pat_flat[i*PAT_W +: PAT_W] = ent_pat[i];

    always_comb begin
      ent_act[i] = WR_IDLE;
      if (ins_go) begin
        if (ins_hit) begin
          if (ins_match[i]) ent_act[i] = WR_SET;
        end else if (victim == IW'(i)) begin
          ent_act[i] = WR_ALLOC;
        end
      end
    end
  end

  always_comb begin
    lk_idx     = '0;
    ins_idx    = '0;
    lk_sel_pat = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (lk_match[k]) begin
        lk_idx     = IW'(k);
        lk_sel_pat = lk_sel_pat | ent_pat[k];
      end
      if (ins_match[k]) ins_idx = IW'(k);
    end
  end

  assign lk_hit    = lk_valid & (|lk_match);
  assign lk_bit    = lk_hit & lk_sel_pat[lk_pos];
  assign stall_out = spec_hazard & ~lk_bit;
  assign b_idx     = ins_hit ? ins_idx : victim;

  fht_lru #(
    .N (ENTRIES)
  ) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (ent_valid),
    .a_touch   (lk_hit),
    .a_idx     (lk_idx),
    .b_touch   (ins_go),
    .b_idx     (b_idx),
    .victim    (victim)
  );

  AST_TAGS_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R8
  AST_STALL_NEEDS_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
    stall_out |-> spec_hazard); // R4
  AST_FILL_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_go && !ins_hit && !(&ent_valid)) |-> !ent_valid[victim]); // R8
  AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_branch) |=> ($stable(ent_valid) && $stable(pat_flat))); // R5
endmodule

// File: tb/fh_history_table_tb.sv
`timescale 1ns/1ps
module fh_history_table_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, spec_hazard, ins_valid, ins_branch;
  logic [16:0] lk_pc, ins_pc;
  logic        lk_hit, lk_bit, stall_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  fh_history_table u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .spec_hazard(spec_hazard),
    .lk_hit(lk_hit), .lk_bit(lk_bit), .stall_out(stall_out),
    .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_branch(ins_branch)
  );

  // reference model
  bit          m_valid [4];
  bit [10:0]   m_tag   [4];
  bit [31:0]   m_pat   [4];
  int          m_rank  [4];

  function automatic int m_find(bit [16:0] pc);
    for (int k = 0; k < 4; k++)
      if (m_valid[k] && m_tag[k] == pc[16:6]) return k;
    return -1;
  endfunction

  task automatic m_touch(int e);
    int r;
    r = m_rank[e];
    for (int k = 0; k < 4; k++) if (m_rank[k] > r) m_rank[k]--;
    m_rank[e] = 3;
  endtask

  task automatic m_reset();
    for (int k = 0; k < 4; k++) begin
      m_valid[k] = 0; m_tag[k] = '0; m_pat[k] = '0; m_rank[k] = k;
    end
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit lkv, bit [16:0] lpc, bit sp,
                      bit iv, bit [16:0] ipc, bit br);
    int  li, ii, v;
    bit  eh, eb;
    lk_valid = lkv; lk_pc = lpc; spec_hazard = sp;
    ins_valid = iv; ins_pc = ipc; ins_branch = br;
    #1;
    li = m_find(lpc);
    eh = lkv && (li >= 0);
    eb = eh && m_pat[li][lpc[5:1]];
    chk(req, "lk_hit", lk_hit, eh);
    chk(req, "lk_bit", lk_bit, eb);
    chk(req, "stall_out", stall_out, sp && !eb);
    @(posedge clk);
    if (eh) m_touch(li);
    if (iv && !br) begin
      ii = m_find(ipc);
      if (ii >= 0) begin
        m_pat[ii][ipc[5:1]] = 1'b1;
        m_touch(ii);
      end else begin
        v = -1;
        for (int k = 3; k >= 0; k--) if (!m_valid[k]) v = k;
        if (v < 0) for (int k = 0; k < 4; k++) if (m_rank[k] == 0) v = k;
        m_valid[v] = 1; m_tag[v] = ipc[16:6];
        m_pat[v] = '0; m_pat[v][ipc[5:1]] = 1'b1;
        m_touch(v);
      end
    end
    @(negedge clk);
  endtask

  function automatic bit [16:0] mkpc(int tag, int pos, bit b0);
    return {11'(tag), 5'(pos), b0};
  endfunction

  task automatic do_reset();
    lk_valid = 0; lk_pc = '0; spec_hazard = 0;
    ins_valid = 0; ins_pc = '0; ins_branch = 0;
    rst_n = 0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R7: empty after reset
    for (int t = 0; t < 8; t++) step("R7", 1, mkpc(t * 37, t * 3, 0), 1, 0, 0, 0);
    // R2 R4: insert then hit with set bit cancels stall
    step("R2", 0, 0, 0, 1, mkpc(5, 7, 0), 0);
    step("R2", 1, mkpc(5, 7, 0), 1, 0, 0, 0);
    step("R4", 1, mkpc(5, 7, 0), 0, 0, 0, 0);
    // R1: bit 0 ignored on lookup and insert
    step("R1", 1, mkpc(5, 7, 1), 1, 0, 0, 0);
    step("R1", 0, 0, 0, 1, mkpc(5, 9, 1), 0);
    step("R1", 1, mkpc(5, 9, 0), 1, 0, 0, 0);
    // R3 R6: other bits of new entry clear
    for (int p = 0; p < 32; p++) step("R6", 1, mkpc(5, p, 0), 1, 0, 0, 0);
    step("R3", 1, mkpc(5, 8, 0), 1, 0, 0, 0);
    // R11: no lookup, no hit
    step("R11", 0, mkpc(5, 7, 0), 1, 0, 0, 0);
    // R5: branch insert ignored
    step("R5", 0, 0, 0, 1, mkpc(200, 3, 0), 1);
    step("R5", 1, mkpc(200, 3, 0), 1, 0, 0, 0);
    step("R5", 0, 0, 0, 1, mkpc(5, 20, 0), 1);
    step("R5", 1, mkpc(5, 20, 0), 1, 0, 0, 0);
    // R1 R2: sweep even positions of one block
    for (int p = 0; p < 32; p += 2) step("R2", 0, 0, 0, 1, mkpc(9, p, 0), 0);
    for (int p = 0; p < 32; p++) step("R1", 1, mkpc(9, p, 0), 1, 0, 0, 0);
    // R8 R9: fill, then evict least recent
    do_reset();
    for (int t = 0; t < 4; t++) step("R8", 0, 0, 0, 1, mkpc(100 + t, t, 0), 0);
    step("R9", 0, 0, 0, 1, mkpc(300, 1, 0), 0);
    for (int t = 0; t < 4; t++) step("R9", 1, mkpc(100 + t, t, 0), 1, 0, 0, 0);
    step("R9", 1, mkpc(300, 1, 0), 1, 0, 0, 0);
    // R10: same-cycle lookup and insert of the same address
    step("R10", 1, mkpc(400, 4, 0), 1, 1, mkpc(400, 4, 0), 0);
    step("R10", 1, mkpc(400, 4, 0), 1, 0, 0, 0);
    // R9 R10: streams with both ports active on a small tag pool
    for (int n = 0; n < 3000; n++) begin
      int tl, pl, ti, pi;
      tl = $urandom_range(0, 5); pl = $urandom_range(0, 31);
      ti = $urandom_range(0, 5); pi = $urandom_range(0, 31);
      step("R10", 1'($urandom_range(0, 3) != 0), mkpc(tl * 129, pl, 1'($urandom_range(0, 1))),
           1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), mkpc(ti * 129, pi, 0), 1'($urandom_range(0, 7) == 0));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule